// File: doc/BRIEF.md
# Console Start/Stop and Single-Step Sequencer

This block decides when the processor may execute, based on the operator panel switches and two status pulses from the processor: one marking the end of a memory cycle and one marking the end of an instruction. It grants execution in four situations. In free-running mode it grants continuously. After the run switch is moved to idle, it keeps granting until the next stop boundary. After a step button press in idle, it grants until the step's stop boundary. In all other cases execution is not permitted.

One switch sets the stop granularity for both step presses and run-to-idle transitions: either a whole instruction or a single memory cycle. A chain of enable interlocks decides which switches are effective. The panel key must be unlocked. The halt switch counts only in idle. The granularity, reset and hold-operation-register switches count only while halt is effective.

The block also produces three more outputs:
- a quiesce signal that stops the timers, DMA and interrupts once the processor has stopped;
- a hold signal for the operation register during a step;
- a console system-reset pulse that sets the interrupt mask to all ones.

Top module: `console_step_ctrl`

## Requirements
- R1: With instruction granularity, a rising step edge in idle with the panel unlocked raises `exec_permit_o` from the next cycle. The signal stays high through end-of-memory-cycle pulses and drops in the cycle after the `instr_done_i` pulse.
- R2: Cycle granularity is in force when `fine_sw_i`, halt effective, panel unlocked and run switch idle are all true. In that case, a step drops `exec_permit_o` in the cycle after the first `mem_cyc_done_i` (or `instr_done_i`) pulse.
- R3: `run_sw_i`=1 raises `exec_permit_o` one cycle after it is sampled. Returning it to 0 keeps the permit until the boundary of the granularity sampled at that moment. A boundary pulse in the same cycle as the switch-off also counts, so the permit drops on the next cycle.
- R4: Halt is effective only when `halt_sw_i`=1, `panel_unlock_i`=1 and `run_sw_i`=0. `quiesce_o` is high exactly when halt is effective and the sequencer is stopped, so it stays low while a stop is still pending.
- R5: The step button is edge-triggered. Holding it launches no further step. An edge that arrives while a step is running is discarded. An edge while the panel is locked does nothing.
- R6: A rising edge of `reset_btn_i` while halt is effective drives `sys_reset_o` high for exactly RST_CYC cycles. On the first of those cycles the interrupt mask is already all ones. The pulse also forces the sequencer to stop. A reset edge while halt is not effective is ignored.
- R7: `opreg_hold_o` is high only during a step with `keep_op_sw_i`=1 and halt effective. It drops while `op_forces_i`=1, which marks shift, multiply, divide or modify-memory instructions that must still write the operation register.
- R8: `fine_sw_i`=1 while halt is not effective leaves instruction granularity in force.
- R9: After `rst_n` is released, with the run switch at idle, `exec_permit_o`, `sys_reset_o` and `opreg_hold_o` are 0 and `irq_mask_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_sw_i | input | 1 | 1 = run, 0 = idle |
| step_btn_i | input | 1 | Step button level |
| fine_sw_i | input | 1 | 1 = stop per memory cycle |
| halt_sw_i | input | 1 | Halt switch |
| reset_btn_i | input | 1 | Console reset button level |
| keep_op_sw_i | input | 1 | Hold operation register while stepping |
| panel_unlock_i | input | 1 | Panel key unlocked |
| mem_cyc_done_i | input | 1 | End-of-memory-cycle pulse |
| instr_done_i | input | 1 | End-of-instruction pulse |
| op_forces_i | input | 1 | Current instruction must write the operation register |
| exec_permit_o | output | 1 | Processor may execute |
| quiesce_o | output | 1 | Inhibit timers, DMA and interrupts |
| opreg_hold_o | output | 1 | Block operation-register updates |
| sys_reset_o | output | 1 | Console system reset pulse |
| irq_mask_o | output | MASK_W | Interrupt mask register |

## Verification
The bench builds the block with MASK_W=12 and RST_CYC=3. The narrow mask makes the all-ones value easy to compare. The short pulse lets the bench observe both edges of the console reset within a few cycles, including the forced stop of a step that is still running. Every stop path is driven with boundary pulses placed one cycle apart, so the permit edge can be counted exactly against each granularity and interlock setting.

// File: rtl/console_step_pkg.sv
package console_step_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2,
    SQ_STEP  = 2'd3
  } seq_state_e;

  // Boundary test: cycle granularity stops on any cycle end (an
  // instruction end is also a cycle end); instruction granularity
  // waits for the instruction end.
  function automatic logic stop_hit(input logic fine, input logic mem_end,
                                    input logic ins_end);
    return fine ? (mem_end | ins_end) : ins_end;
  endfunction
endpackage

// File: rtl/panel_gate.sv
module panel_gate (
  input  logic run_sw_i,
  input  logic halt_sw_i,
  input  logic fine_sw_i,
  input  logic keep_op_sw_i,
  input  logic panel_unlock_i,
  output logic halt_ok_o,
  output logic fine_ok_o,
  output logic keep_ok_o,
  output logic step_ok_o
);
  // Interlock chain: key -> idle -> halt -> dependent switches
  assign halt_ok_o = halt_sw_i & panel_unlock_i & ~run_sw_i;
  assign fine_ok_o = fine_sw_i & halt_ok_o;
  assign keep_ok_o = keep_op_sw_i & halt_ok_o;
  assign step_ok_o = panel_unlock_i;
endmodule

// File: rtl/edge_pick.sv
module edge_pick #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/reset_pulse.sv
module reset_pulse #(
  parameter int MASK_W  = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  output logic              sys_reset_o,
  output logic [MASK_W-1:0] mask_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);

  logic [CW-1:0]     cnt_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (fire_i) begin
      cnt_q  <= LOAD;
      mask_q <= '1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sys_reset_o = (cnt_q != '0);
  assign mask_o      = mask_q;

  AST_MASK_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_o) |-> (&mask_q)); // R6
  AST_PULSE_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_o && !fire_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import console_step_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic step_go_i,
  input  logic fine_i,
  input  logic mem_end_i,
  input  logic ins_end_i,
  input  logic force_idle_i,
  output logic active_o,
  output logic stepping_o
);
  seq_state_e st_q, st_d;
  logic       gran_q, gran_d;

  always_comb begin
    st_d   = st_q;
    gran_d = gran_q;
    if (force_idle_i) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (run_i) st_d = SQ_RUN;
          else if (step_go_i) begin
            st_d   = SQ_STEP;
            gran_d = fine_i;
          end
        end
        SQ_RUN: begin
          if (!run_i) begin
            gran_d = fine_i;
            st_d   = stop_hit(fine_i, mem_end_i, ins_end_i) ? SQ_IDLE : SQ_DRAIN;
          end
        end
        SQ_DRAIN, SQ_STEP: begin
          if (stop_hit(gran_q, mem_end_i, ins_end_i)) st_d = SQ_IDLE;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      gran_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gran_q <= gran_d;
    end
  end

  assign active_o   = (st_q != SQ_IDLE);
  assign stepping_o = (st_q == SQ_STEP);

  AST_INSTR_STEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_STEP && !gran_q && ins_end_i) |=> (st_q == SQ_IDLE)); // R1
  AST_CYCLE_STEP_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_STEP && gran_q && mem_end_i) |=> (st_q == SQ_IDLE)); // R2
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_DRAIN && !gran_q && !ins_end_i && !force_idle_i) |=> (st_q == SQ_DRAIN)); // R3
  AST_STEP_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !run_i && !step_go_i) |=> (st_q == SQ_IDLE)); // R5
  AST_FORCED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle_i |=> (st_q == SQ_IDLE)); // R6
endmodule

// File: rtl/console_step_ctrl.sv
module console_step_ctrl #(
  parameter int MASK_W  = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_sw_i,
  input  logic              step_btn_i,
  input  logic              fine_sw_i,
  input  logic              halt_sw_i,
  input  logic              reset_btn_i,
  input  logic              keep_op_sw_i,
  input  logic              panel_unlock_i,
  input  logic              mem_cyc_done_i,
  input  logic              instr_done_i,
  input  logic              op_forces_i,
  output logic              exec_permit_o,
  output logic              quiesce_o,
  output logic              opreg_hold_o,
  output logic              sys_reset_o,
  output logic [MASK_W-1:0] irq_mask_o
);
  logic       halt_ok, fine_ok, keep_ok, step_ok;
  logic [1:0] rise;
  logic       step_go, reset_fire, active, stepping;

  panel_gate u_gate (
    .run_sw_i      (run_sw_i),
    .halt_sw_i     (halt_sw_i),
    .fine_sw_i     (fine_sw_i),
    .keep_op_sw_i  (keep_op_sw_i),
    .panel_unlock_i(panel_unlock_i),
    .halt_ok_o     (halt_ok),
    .fine_ok_o     (fine_ok),
    .keep_ok_o     (keep_ok),
    .step_ok_o     (step_ok)
  );

  edge_pick #(.W(2)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({reset_btn_i, step_btn_i}),
    .rise_o(rise)
  );

  assign step_go    = rise[0] & step_ok;
  assign reset_fire = rise[1] & halt_ok;

  reset_pulse #(.MASK_W(MASK_W), .RST_CYC(RST_CYC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (reset_fire),
    .sys_reset_o(sys_reset_o),
    .mask_o     (irq_mask_o)
  );

  stop_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_sw_i),
    .step_go_i   (step_go),
    .fine_i      (fine_ok),
    .mem_end_i   (mem_cyc_done_i),
    .ins_end_i   (instr_done_i),
    .force_idle_i(sys_reset_o),
    .active_o    (active),
    .stepping_o  (stepping)
  );

  assign exec_permit_o = active;
  assign quiesce_o     = halt_ok & ~active;
  assign opreg_hold_o  = keep_ok & stepping & ~op_forces_i;

  AST_QUIESCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    quiesce_o |-> (halt_sw_i && panel_unlock_i && !run_sw_i)); // R4
  AST_HOLD_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    opreg_hold_o |-> (exec_permit_o && !op_forces_i)); // R7
  AST_RESET_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_o) |-> $past(halt_sw_i && panel_unlock_i && !run_sw_i)); // R6
endmodule

// File: tb/console_step_ctrl_tb_top.sv
module console_step_ctrl_tb_top;
  localparam int MW = 12;
  localparam int RC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run, step, fine, halt, rbtn, keep, unlock, memd, insd, forces;
  logic permit, quiesce, hold, sysrst;
  logic [MW-1:0] mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  console_step_ctrl #(.MASK_W(MW), .RST_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_sw_i(run), .step_btn_i(step),
    .fine_sw_i(fine), .halt_sw_i(halt), .reset_btn_i(rbtn),
    .keep_op_sw_i(keep), .panel_unlock_i(unlock), .mem_cyc_done_i(memd),
    .instr_done_i(insd), .op_forces_i(forces), .exec_permit_o(permit),
    .quiesce_o(quiesce), .opreg_hold_o(hold), .sys_reset_o(sysrst),
    .irq_mask_o(mask));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_mem();
    memd = 1; cyc(); memd = 0;
  endtask

  task automatic pulse_ins();
    insd = 1; cyc(); insd = 0;
  endtask

  task automatic idle_all();
    run = 0; step = 0; fine = 0; halt = 0; rbtn = 0; keep = 0;
    unlock = 1; memd = 0; insd = 0; forces = 0;
  endtask

  task automatic t_reset_state();
    chk("R9 permit", permit, 0);
    chk("R9 sysreset", sysrst, 0);
    chk("R9 hold", hold, 0);
    chk("R9 mask", mask, 0);
  endtask

  task automatic t_instr_step();
    idle_all(); cyc();
    step = 1; cyc(); step = 0;
    chk("R1 permit after step", permit, 1);
    pulse_mem();
    chk("R1 permit through cycle end", permit, 1);
    pulse_mem();
    chk("R1 permit through second cycle end", permit, 1);
    pulse_ins();
    chk("R1 stop at instr end", permit, 0);
  endtask

  task automatic t_edge_rules();
    idle_all(); cyc();
    step = 1; cyc();
    chk("R5 step launched", permit, 1);
    pulse_ins();
    chk("R5 stopped", permit, 0);
    cyc(3);
    chk("R5 held button no relaunch", permit, 0);
    step = 0; cyc();
    step = 1; cyc(); step = 0; cyc();
    step = 1; cyc(); step = 0;
    pulse_ins();
    chk("R5 edge during step discarded", permit, 0);
    cyc(2);
    chk("R5 still stopped", permit, 0);
    unlock = 0; step = 1; cyc();
    chk("R5 locked panel ignores step", permit, 0);
    unlock = 1; cyc();
    chk("R5 no edge on unlock", permit, 0);
    step = 0; cyc();
  endtask

  task automatic t_cycle_step();
    idle_all(); halt = 1; fine = 1; cyc();
    chk("R4 quiesce in halt idle", quiesce, 1);
    step = 1; cyc(); step = 0;
    chk("R2 permit after step", permit, 1);
    chk("R4 no quiesce while stepping", quiesce, 0);
    pulse_mem();
    chk("R2 stop at cycle end", permit, 0);
    chk("R4 quiesce after stop", quiesce, 1);
    step = 1; cyc(); step = 0;
    pulse_ins();
    chk("R2 instr end also stops", permit, 0);
  endtask

  task automatic t_fine_without_halt();
    idle_all(); fine = 1; cyc();
    step = 1; cyc(); step = 0;
    pulse_mem();
    chk("R8 cycle end ignored", permit, 1);
    pulse_ins();
    chk("R8 instr end stops", permit, 0);
  endtask

  task automatic t_run_idle();
    idle_all(); run = 1; cyc();
    chk("R3 run permits", permit, 1);
    pulse_ins();
    chk("R3 run continues", permit, 1);
    run = 0; cyc();
    chk("R3 drain keeps permit", permit, 1);
    pulse_mem();
    chk("R3 drain ignores cycle end", permit, 1);
    halt = 1; cyc();
    chk("R4 no quiesce while draining", quiesce, 0);
    pulse_ins();
    chk("R3 drain stops at instr end", permit, 0);
    chk("R4 quiesce once stopped", quiesce, 1);
    halt = 0; run = 1; cyc();
    run = 0; halt = 1; fine = 1; memd = 1; cyc(); memd = 0;
    chk("R3 same-cycle boundary stops", permit, 0);
    unlock = 0; cyc();
    chk("R4 locked panel no quiesce", quiesce, 0);
    unlock = 1;
  endtask

  task automatic t_console_reset();
    idle_all(); rbtn = 1; cyc();
    chk("R6 ignored without halt", sysrst, 0);
    chk("R6 mask untouched", mask, 0);
    rbtn = 0; halt = 1; cyc();
    step = 1; cyc(); step = 0;
    chk("R6 step running", permit, 1);
    rbtn = 1; cyc();
    chk("R6 pulse starts", sysrst, 1);
    chk("R6 mask all ones", mask, {MW{1'b1}});
    cyc();
    chk("R6 step forced stop", permit, 0);
    cyc();
    chk("R6 pulse third cycle", sysrst, 1);
    cyc();
    chk("R6 pulse ends after RST_CYC", sysrst, 0);
    rbtn = 0; cyc();
  endtask

  task automatic t_keep_op();
    idle_all(); halt = 1; keep = 1; cyc();
    chk("R7 no hold when stopped", hold, 0);
    step = 1; cyc(); step = 0;
    chk("R7 hold during step", hold, 1);
    forces = 1; #1;
    chk("R7 forced write releases hold", hold, 0);
    forces = 0; #1;
    halt = 0; #1;
    chk("R7 no hold without halt", hold, 0);
    halt = 1; pulse_ins();
    chk("R7 hold ends with step", hold, 0);
  endtask

  initial begin
    idle_all();
    cyc(2);
    rst_n = 1;
    cyc();
    t_reset_state();
    t_instr_step();
    t_edge_rules();
    t_cycle_step();
    t_fine_without_halt();
    t_run_idle();
    t_keep_op();
    t_console_reset();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule